// File: doc/BRIEF.md
# Multiply-Accumulate Rounding Shift Unit

This unit performs the accumulate step of an integer DCT or FFT butterfly. It takes a signed accumulator T and two signed factors A and B. It forms the full double-width product A·B, then adds it to T or subtracts it from T. For a non-zero shift count n, it applies round-half-up and an arithmetic right shift by n. The result is an XLEN-bit word. The accumulator is sign-extended into the double-width domain, so no precision is lost before the rounding step.

The datapath has two pipeline stages. The first stage registers the product together with the accumulator, the shift count and the mode. The second stage performs the addition or subtraction, the rounding and the shift, and registers the result. Each valid input produces exactly one valid output two clock edges later. The result register keeps its value between operations.

Top module: `mrs_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_result` are cleared to zero by that edge.
- R2: `out_valid` is high exactly two clock edges after an edge at which `in_valid` was high, and low otherwise.
- R3: With `in_mode` = 0 (add) and `in_shift` = 0, the result is (T + A·B) modulo 2^XLEN.
- R4: With `in_mode` = 1 (subtract) and `in_shift` = 0, the result is (T − A·B) modulo 2^XLEN.
- R5: With `in_mode` = 0 and 0 < n < XLEN, the result is floor((T + A·B)/2^n + 1/2) modulo 2^XLEN, where T, A and B are two's complement signed values.
- R6: With `in_mode` = 1 and 0 < n < XLEN, the result is floor((T − A·B)/2^n + 1/2) modulo 2^XLEN.
- R7: A value exactly halfway between two results rounds toward plus infinity. At XLEN = 8, T = −3, A·B = 0, n = 1 gives 0xFF (−1), and T = 3 gives 0x02.
- R8: The product is used at full double width before the shift. At XLEN = 8, A = B = −128, T = 0, n = 7, add gives 0x80, and n = 1 gives 0x00.
- R9: Inputs presented while `in_valid` is low have no effect: `out_result` holds its last value and `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| in_mode | input | 1 | 0 = add product, 1 = subtract product |
| in_shift | input | $clog2(XLEN) | Right shift count n |
| in_t | input | XLEN | Signed accumulator T |
| in_a | input | XLEN | Signed factor A |
| in_b | input | XLEN | Signed factor B |
| out_valid | output | 1 | Result is valid |
| out_result | output | XLEN | Rounded, shifted result |

## Verification
The hardest case to reach is the one where the upper half of the double-width sum decides the result. This needs a product near ±2^(2·XLEN−2) combined with a large shift, so that truncating the product early would change the answer. Exact rounding ties are equally hard to reach. The bench runs at XLEN = 8. It sweeps every shift count and both modes over a grid of factors that contains the extreme values −128 and 127 and accumulators at both ends of the range. It also drives directed tie cases with a zero product and odd accumulators.

// File: rtl/mrs_pkg.sv
// Package: shared types for the multiply-accumulate rounding shift unit.
// Assumes: mode is one bit, with add encoded as 0 and subtract as 1.
package mrs_pkg;
    typedef enum logic {
        MRS_ADD = 1'b0,
        MRS_SUB = 1'b1
    } mrs_mode_e;
endpackage

// File: rtl/mrs_mul.sv
// Module: mrs_mul
// Signed full-width multiplier: both W-bit operands are two's complement,
// and the 2W-bit product is exact. Purely combinational.
module mrs_mul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    // Exact signed product.
    assign p = $signed(a) * $signed(b);
endmodule

// File: rtl/mrs_accum.sv
// Module: mrs_accum
// Sign-extends the accumulator to 2W+1 bits and adds or subtracts the
// 2W-bit product. Subtraction adds the inverted product plus one.
// Assumes: the product is a signed 2W-bit value.
module mrs_accum #(
    parameter int W = 64,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic [W-1:0]   t,
    input  logic [2*W-1:0] p,
    input  logic           sub,
    output logic [2*W:0]   s
);
    import mrs_pkg::*;
    localparam int SW = 2 * W + 1;

    logic [SW-1:0] t_ext;
    logic [SW-1:0] p_ext;

    // Sign extension of both operands into the wide domain.
    always_comb begin
        t_ext = {{(W + 1){t[W-1]}}, t};
        p_ext = {p[2*W-1], p};
    end

    generate
        if (SHARED_ADDER) begin : g_shared
            // One adder: subtraction is the inverted product with carry in.
            always_comb s = t_ext + (p_ext ^ {SW{sub}}) + {{(SW - 1){1'b0}}, sub};
        end else begin : g_split
            // Separate sum and difference, selected afterwards.
            always_comb s = (mrs_mode_e'(sub) == MRS_SUB) ? (t_ext - p_ext) : (t_ext + p_ext);
        end
    endgenerate
endmodule

// File: rtl/mrs_round.sv
// Module: mrs_round
// Adds half an output LSB (2^(n-1)) to the wide value when n > 0, shifts it
// right arithmetically by n and keeps the low W bits. With n = 0 it keeps
// the low W bits unchanged.
// Assumes: n < W.
module mrs_round #(
    parameter int W  = 64,
    parameter int NW = 6
) (
    input  logic [2*W:0]  s,
    input  logic [NW-1:0] n,
    output logic [W-1:0]  r
);
    localparam int SW = 2 * W + 1;

    logic [SW-1:0] half;
    logic [SW-1:0] biased;
    logic [SW-1:0] shifted;

    // Rounding constant: a single bit below the new LSB.
    always_comb begin
        half = '0;
        if (n != '0) half[n - 1'b1] = 1'b1;
    end

    // Bias, arithmetic shift and truncation.
    always_comb begin
        biased  = s + half;
        shifted = $unsigned($signed(biased) >>> n);
        r       = shifted[W-1:0];
    end
endmodule

// File: rtl/mrs_unit.sv
// Module: mrs_unit (top)
// Two-stage multiply-accumulate with round-half-up right shift.
// Stage 1 registers the exact product together with T, n and the mode.
// Stage 2 accumulates, rounds, shifts and registers the result.
// Assumes: synchronous active-low reset; in_shift < XLEN.
module mrs_unit #(
    parameter int XLEN = 64,
    localparam int NW  = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_mode,
    input  logic [NW-1:0]   in_shift,
    input  logic [XLEN-1:0] in_t,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0]   prod;
    logic [PW-1:0]   s1_prod;
    logic [XLEN-1:0] s1_t;
    logic [NW-1:0]   s1_n;
    logic            s1_sub;
    logic            s1_v;
    logic [PW:0]     acc;
    logic [XLEN-1:0] rnd;

    mrs_mul #(.W(XLEN)) u_mul (
        .a (in_a),
        .b (in_b),
        .p (prod)
    );

    // Stage 1 register: capture the product and the controls on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_prod <= '0;
            s1_t    <= '0;
            s1_n    <= '0;
            s1_sub  <= 1'b0;
        end else begin
            s1_v <= in_valid;
            if (in_valid) begin
                s1_prod <= prod;
                s1_t    <= in_t;
                s1_n    <= in_shift;
                s1_sub  <= in_mode;
            end
        end
    end

    mrs_accum #(.W(XLEN), .SHARED_ADDER(1'b1)) u_acc (
        .t   (s1_t),
        .p   (s1_prod),
        .sub (s1_sub),
        .s   (acc)
    );

    mrs_round #(.W(XLEN), .NW(NW)) u_rnd (
        .s (acc),
        .n (s1_n),
        .r (rnd)
    );

    // Stage 2 register: publish the result; it holds while no operation is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= s1_v;
            if (s1_v) out_result <= rnd;
        end
    end
endmodule

// File: rtl/mrs_unit_chk.sv
// Module: mrs_unit_chk
// Port-level properties of mrs_unit, attached to every instance by bind.
module mrs_unit_chk #(
    parameter int XLEN = 64,
    localparam int NW  = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_mode,
    input logic [NW-1:0]   in_shift,
    input logic [XLEN-1:0] in_t,
    input logic [XLEN-1:0] in_a,
    input logic [XLEN-1:0] in_b,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result
);
    logic [XLEN-1:0] lo_add;
    logic [XLEN-1:0] lo_sub;

    // Low-word reference for n = 0: an unsigned multiply gives the same low bits.
    always_comb begin
        lo_add = in_t + in_a * in_b;
        lo_sub = in_t - in_a * in_b;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_result == '0));

    a_r2_valid_two_later: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    a_r3_add_noshift: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shift == '0 && !in_mode) |=> ##1 (out_result == $past(lo_add, 2)));

    a_r4_sub_noshift: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_shift == '0 && in_mode) |=> ##1 (out_result == $past(lo_sub, 2)));

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result));
endmodule

bind mrs_unit mrs_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_mrs_unit.sv
// Bench for mrs_unit at XLEN = 8: sweeps shift counts, modes and an operand
// grid, plus directed tie and wide-product cases, against integer arithmetic.
module sim_mrs_unit;
    localparam int XLEN   = 8;
    localparam int NW     = 3;
    localparam int PERIOD = 10;
    localparam int LIMIT  = 200000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_mode;
    logic [NW-1:0]   in_shift;
    logic [XLEN-1:0] in_t, in_a, in_b;
    logic            out_valid;
    logic [XLEN-1:0] out_result;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    mrs_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_shift(in_shift), .in_t(in_t), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    always #(PERIOD / 2) clk = ~clk;

    // Expected result from full-precision integer arithmetic.
    function automatic logic [XLEN-1:0] model(input int t, input int a, input int b,
                                              input int n, input bit sub);
        longint r;
        r = sub ? longint'(t) - longint'(a) * longint'(b)
                : longint'(t) + longint'(a) * longint'(b);
        if (n > 0) r = (r + (longint'(1) <<< (n - 1))) >>> n;
        return r[XLEN-1:0];
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Apply one operation and check the output two edges later.
    task automatic run(input string req, input int t, input int a, input int b,
                       input int n, input bit sub);
        logic [XLEN-1:0] exp;
        exp = model(t, a, b, n, sub);
        @(negedge clk);
        in_valid = 1'b1; in_mode = sub; in_shift = NW'(n);
        in_t = XLEN'(t); in_a = XLEN'(a); in_b = XLEN'(b);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(req, out_result, exp);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_shift = '0;
        in_t = '0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        check("R1 reset result", out_result, '0);
        check("R1 reset valid", {7'd0, out_valid}, 8'd0);
        rst_n = 1'b1;

        // R2: out_valid timing.
        @(negedge clk);
        in_valid = 1'b1; in_t = 8'd5; in_a = 8'd2; in_b = 8'd3; in_shift = '0; in_mode = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid after one edge", {7'd0, out_valid}, 8'd0);
        @(negedge clk);
        check("R2 valid after two edges", {7'd0, out_valid}, 8'd1);
        check("R3 simple add", out_result, 8'd11);
        @(negedge clk);
        check("R2 valid drops", {7'd0, out_valid}, 8'd0);

        // R9: inputs with in_valid low do not change the result.
        in_t = 8'h7F; in_a = 8'h80; in_b = 8'h80; in_mode = 1'b1; in_shift = 3'd5;
        repeat (3) @(negedge clk);
        check("R9 result held", out_result, 8'd11);
        check("R9 valid low", {7'd0, out_valid}, 8'd0);

        // R7: ties round upward.
        run("R7 tie negative", -3, 0, 0, 1, 1'b0);
        check("R7 tie negative value", out_result, 8'hFF);
        run("R7 tie positive", 3, 0, 0, 1, 1'b1);
        check("R7 tie positive value", out_result, 8'h02);

        // R8: full-width product before the shift.
        run("R8 wide product n7", 0, -128, -128, 7, 1'b0);
        check("R8 wide product value", out_result, 8'h80);
        run("R8 wide product n1", 0, -128, -128, 1, 1'b0);

        // Sweep: both modes, every shift, an operand grid with the extremes.
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < XLEN; n++) begin
                for (int ti = 0; ti < 8; ti++) begin
                    int tv;
                    case (ti)
                        0: tv = -128; 1: tv = -1; 2: tv = 0; 3: tv = 1;
                        4: tv = 127;  5: tv = -3; 6: tv = 37; default: tv = -77;
                    endcase
                    for (int a = -128; a < 128; a += 17) begin
                        for (int b = -128; b < 128; b += 17) begin
                            int bb;
                            bb = (b == 127 - (127 + 128) % 17) ? 127 : b;
                            if (n == 0 && m == 0) run("R3 add no shift", tv, a, bb, n, 1'b0);
                            else if (n == 0)      run("R4 sub no shift", tv, a, bb, n, 1'b1);
                            else if (m == 0)      run("R5 add round shift", tv, a, bb, n, 1'b0);
                            else                  run("R6 sub round shift", tv, a, bb, n, 1'b1);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT && !done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, LIMIT);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule